// File: doc/BRIEF.md
# Prioritised Interrupt Controller Core

This block collects eight interrupt request lines and decides which one the processor should service next. It holds three 8-bit state registers: pending requests, in-service pins and masked pins. Priority rotates around a programmable lowest-priority pointer, and the block raises a single interrupt line toward the processor. The processor accepts an interrupt by returning the pin number on an acknowledge strobe. It can also accept one by reading in poll mode. The block presents the vector base combined with the current winning pin on a vector output; pin 7 is used as a spurious code when nothing wins.

Software uses a byte-wide register port with one address bit. An initialization sequence configures the controller: a start command at the even address, then up to three words at the odd address. After that, operation commands manage the mask, end-of-interrupt, rotation and readback. Request lines are sampled on their rising edges.

Top module: `prio_irq_controller`

## Requirements
- R1: An even-address write with bit 4 set restarts initialization. It clears the mask to 0x00, sets the lowest-priority pointer to 7 (pin 0 highest), selects request readback, turns poll off and leaves the block not ready. The sequence continues only if bit 1 is 0 and bit 0 is 1; otherwise odd-address writes load the mask and the block stays not ready.
- R2: After a valid start, odd-address writes are taken in order as the vector base (bits 7:3), a cascade word with no effect, and the mode word. A mode word with bit 0 clear is rejected, and the block stays waiting for a mode word. An accepted mode word sets automatic end-of-interrupt from bit 1 and nested-cascade mode from bit 4, and makes the block ready. From then on, odd-address writes load the mask.
- R3: While not ready, rising edges on request lines are not captured and `intOut` stays low.
- R4: While ready, a rising edge on a request line sets its request bit. With request readback selected, an even-address read returns the request register.
- R5: The winner is found by scanning pins from pointer+1, wrapping through all eight. The scan skips masked pins and ends with no winner at the first in-service pin. `vectorOut` is base*8 + winner, or base*8 + 7 when there is no winner.
- R6: `intOut` rises one cycle after a winner exists while ready. It stays high until an acceptance, and is evaluated again in the following cycle.
- R7: On acceptance of a pin, its request bit is cleared if its line is low and kept if the line is high. Without automatic end-of-interrupt, the pin's in-service bit is set.
- R8: An even-address command with bit 5 set and bit 6 clear clears the highest-priority in-service bit.
- R9: An even-address command with bits 5 and 6 set clears the in-service bit named by bits 2:0.
- R10: Bit 7 of any end-of-interrupt/priority command (bit 3 and bit 4 clear) is latched as the rotate flag. With end-of-interrupt and rotate, the cleared pin becomes the lowest priority. Bits 7 and 6 set with bit 5 clear load the pointer from bits 2:0.
- R11: In automatic end-of-interrupt mode, acceptance sets no in-service bit. If the rotate flag is set, the accepted pin becomes the lowest priority.
- R12: An even-address write with bit 3 set and bit 4 clear is a readback/poll command. If bit 1 is set, bit 0 selects in-service (1) or request (0) readback and bit 2 sets poll mode. If bit 6 is set, the whole command is ignored.
- R13: A read while poll is on turns poll off and returns 0x80 | winner, accepting the winner; it returns 0x00 when there is no winner. Otherwise an odd-address read returns the mask.
- R14: On an instance built as master with nested-cascade mode set, in-service bit 2 does not stop the priority scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 8 | Request lines, active high |
| cpuWr | input | 1 | Register write strobe |
| cpuRd | input | 1 | Register read strobe |
| cpuAddr | input | 1 | Register address bit |
| cpuWrData | input | 8 | Write data |
| cpuRdData | output | 8 | Read data, valid while cpuRd is high |
| ackValid | input | 1 | Interrupt acknowledge strobe |
| ackPin | input | 3 | Pin being accepted |
| intOut | output | 1 | Registered interrupt request to the processor |
| vectorOut | output | 8 | Vector base plus current winner |

## Verification
The hardest state to reach is a rotated priority order combined with in-service bits that block part of the scan. In that state the same pending requests must produce different winners depending on history. The stimulus builds it step by step: it nests a higher request over an in-service one, then retires the bits with non-specific, specific and rotating end-of-interrupt commands. After that it moves the pointer explicitly and compares the vectors. Poll-mode acceptance and nested-cascade mode are reached later, by re-running initialization while some requests are still latched.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LINES = 8;
  localparam int IDX_W = $clog2(LINES);
  localparam int BASE_W = 8 - IDX_W;

  typedef struct packed {
    logic              initClear;
    logic              loadMask;
    logic [7:0]        maskVal;
    logic              eoiEn;
    logic              eoiSpecific;
    logic [IDX_W-1:0]  eoiPin;
    logic              rotateOn;
    logic              setPrio;
    logic [IDX_W-1:0]  prioVal;
    logic              pollAccept;
  } ctrlStb_t;

  // Scan from low+1 with wrap; stop at a blocking bit, return first eligible.
  function automatic logic [IDX_W:0] pickWinner(
    input logic [LINES-1:0] req,
    input logic [LINES-1:0] block,
    input logic [LINES-1:0] msk,
    input logic [IDX_W-1:0] low
  );
    logic done;
    logic [IDX_W:0] res;
    logic [IDX_W-1:0] p;
    done = 1'b0;
    res = '0;
    for (int k = 0; k < LINES; k++) begin
      p = low + IDX_W'(k + 1);
      if (!done) begin
        if (block[p]) begin
          done = 1'b1;
        end else if (req[p] && !msk[p]) begin
          done = 1'b1;
          res = {1'b1, p};
        end
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWr,
  input  logic             cpuRd,
  input  logic             cpuAddr,
  input  logic [7:0]       cpuWrData,
  output logic [7:0]       cpuRdData,
  input  logic [LINES-1:0] requestQ,
  input  logic [LINES-1:0] serviceQ,
  input  logic [LINES-1:0] maskQ,
  input  logic             winnerValid,
  input  logic [IDX_W-1:0] winnerPin,
  output ctrlStb_t         stb,
  output logic             readyQ,
  output logic             aeoiQ,
  output logic             sfnQ,
  output logic             rotateQ,
  output logic [BASE_W-1:0] baseQ
);
  typedef enum logic [1:0] {STEP_RUN, STEP_BASE, STEP_CASC, STEP_MODE} step_e;

  step_e stepQ;
  logic  readIsrQ;
  logic  pollQ;

  logic wrEven, wrOdd, isStart, isOcw3, isOcw2, startOk;
  assign wrEven  = cpuWr && !cpuAddr;
  assign wrOdd   = cpuWr && cpuAddr;
  assign isStart = wrEven && cpuWrData[4];
  assign isOcw3  = wrEven && !cpuWrData[4] && readyQ && cpuWrData[3];
  assign isOcw2  = wrEven && !cpuWrData[4] && readyQ && !cpuWrData[3];
  assign startOk = !cpuWrData[1] && cpuWrData[0];

  always_comb begin
    stb = '0;
    stb.initClear   = isStart;
    stb.loadMask    = wrOdd && stepQ == STEP_RUN;
    stb.maskVal     = cpuWrData;
    stb.eoiEn       = isOcw2 && cpuWrData[5];
    stb.eoiSpecific = cpuWrData[6];
    stb.eoiPin      = cpuWrData[IDX_W-1:0];
    stb.rotateOn    = cpuWrData[7];
    stb.setPrio     = isOcw2 && !cpuWrData[5] && cpuWrData[6] && cpuWrData[7];
    stb.prioVal     = cpuWrData[IDX_W-1:0];
    stb.pollAccept  = cpuRd && pollQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ    <= STEP_RUN;
      readyQ   <= 1'b0;
      aeoiQ    <= 1'b0;
      sfnQ     <= 1'b0;
      rotateQ  <= 1'b0;
      baseQ    <= '0;
      readIsrQ <= 1'b0;
      pollQ    <= 1'b0;
    end else begin
      if (cpuRd && pollQ) pollQ <= 1'b0;
      if (isStart) begin
        readyQ   <= 1'b0;
        readIsrQ <= 1'b0;
        pollQ    <= 1'b0;
        stepQ    <= startOk ? STEP_BASE : STEP_RUN;
      end else if (wrOdd) begin
        unique case (stepQ)
          STEP_BASE: begin
            baseQ <= cpuWrData[7:IDX_W];
            stepQ <= STEP_CASC;
          end
          STEP_CASC: stepQ <= STEP_MODE;
          STEP_MODE: begin
            if (cpuWrData[0]) begin
              aeoiQ  <= cpuWrData[1];
              sfnQ   <= IS_MASTER && cpuWrData[4];
              readyQ <= 1'b1;
              stepQ  <= STEP_RUN;
            end
          end
          default: ;
        endcase
      end else if (isOcw3) begin
        if (!cpuWrData[6] && cpuWrData[1]) begin
          readIsrQ <= cpuWrData[0];
          pollQ    <= cpuWrData[2];
        end
      end else if (isOcw2) begin
        rotateQ <= cpuWrData[7];
      end
    end
  end

  always_comb begin
    if (pollQ)
      cpuRdData = winnerValid ? {1'b1, {(7-IDX_W){1'b0}}, winnerPin} : 8'h00;
    else if (cpuAddr)
      cpuRdData = maskQ;
    else
      cpuRdData = readIsrQ ? serviceQ : requestQ;
  end

  assert_poll_once_R13: assert property (@(posedge clk) disable iff (!rstN)
    (pollQ && cpuRd && !cpuWr) |=> !pollQ);

  assert_mode_reject_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrOdd && stepQ == STEP_MODE && !cpuWrData[0]) |=> (!readyQ && stepQ == STEP_MODE));

  assert_start_unready_R1: assert property (@(posedge clk) disable iff (!rstN)
    isStart |=> (!readyQ && !pollQ));
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int CASC_LINE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] irqIn,
  input  logic             ackValid,
  input  logic [IDX_W-1:0] ackPin,
  input  ctrlStb_t         stb,
  input  logic             readyQ,
  input  logic             aeoiQ,
  input  logic             sfnQ,
  input  logic             rotateQ,
  output logic [LINES-1:0] requestQ,
  output logic [LINES-1:0] serviceQ,
  output logic [LINES-1:0] maskQ,
  output logic             winnerValid,
  output logic [IDX_W-1:0] winnerPin,
  output logic             intOut
);
  logic [LINES-1:0] irqPrevQ;
  logic [IDX_W-1:0] lowPrioQ;
  logic             intRaisedQ;

  logic [LINES-1:0] blockView;
  logic [IDX_W:0]   winRes, topIsr;
  logic             acceptEn;
  logic [IDX_W-1:0] acceptPin;
  logic [IDX_W-1:0] eoiTarget;
  logic             eoiHit;
  logic [LINES-1:0] reqNext, svcNext;
  logic [IDX_W-1:0] lowNext;

  always_comb begin
    blockView = serviceQ;
    if (sfnQ) blockView[CASC_LINE] = 1'b0;
  end

  assign winRes      = pickWinner(requestQ, blockView, maskQ, lowPrioQ);
  assign winnerValid = winRes[IDX_W];
  assign winnerPin   = winRes[IDX_W-1:0];
  assign topIsr      = pickWinner(serviceQ, '0, '0, lowPrioQ);

  assign acceptEn  = ackValid || (stb.pollAccept && winnerValid);
  assign acceptPin = ackValid ? ackPin : winnerPin;
  assign eoiTarget = stb.eoiSpecific ? stb.eoiPin : topIsr[IDX_W-1:0];
  assign eoiHit    = stb.eoiEn && (stb.eoiSpecific || topIsr[IDX_W]);

  always_comb begin
    reqNext = requestQ;
    svcNext = serviceQ;
    lowNext = lowPrioQ;
    if (readyQ) reqNext = reqNext | (irqIn & ~irqPrevQ);
    if (eoiHit) begin
      svcNext[eoiTarget] = 1'b0;
      if (stb.rotateOn) lowNext = eoiTarget;
    end else if (stb.setPrio) begin
      lowNext = stb.prioVal;
    end
    if (acceptEn) begin
      if (!irqIn[acceptPin]) reqNext[acceptPin] = 1'b0;
      if (aeoiQ) begin
        if (rotateQ) lowNext = acceptPin;
      end else begin
        svcNext[acceptPin] = 1'b1;
      end
    end
    if (stb.initClear) lowNext = '1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPrevQ   <= '0;
      requestQ   <= '0;
      serviceQ   <= '0;
      maskQ      <= '0;
      lowPrioQ   <= '1;
      intRaisedQ <= 1'b0;
    end else begin
      irqPrevQ <= irqIn;
      requestQ <= reqNext;
      serviceQ <= svcNext;
      lowPrioQ <= lowNext;
      if (stb.initClear)     maskQ <= '0;
      else if (stb.loadMask) maskQ <= stb.maskVal;
      if (stb.initClear || !readyQ || acceptEn) intRaisedQ <= 1'b0;
      else if (winnerValid)                     intRaisedQ <= 1'b1;
    end
  end

  assign intOut = intRaisedQ;

  assert_quiet_unready_R3: assert property (@(posedge clk) disable iff (!rstN)
    !readyQ |-> !intOut);

  assert_raise_has_winner_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intOut) |-> $past(winnerValid));

  assert_ack_sets_isr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !aeoiQ && !stb.eoiEn && !stb.initClear) |=> serviceQ[$past(ackPin)]);

  assert_auto_no_isr_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && aeoiQ && !stb.eoiEn) |=> $stable(serviceQ));

  assert_start_pointer_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.initClear |=> (lowPrioQ == '1 && maskQ == '0));
endmodule

// File: rtl/prio_irq_controller.sv
module prio_irq_controller
  import irqc_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1,
  parameter int CASC_LINE = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] irqIn,
  input  logic       cpuWr,
  input  logic       cpuRd,
  input  logic       cpuAddr,
  input  logic [7:0] cpuWrData,
  output logic [7:0] cpuRdData,
  input  logic       ackValid,
  input  logic [2:0] ackPin,
  output logic       intOut,
  output logic [7:0] vectorOut
);
  ctrlStb_t         stb;
  logic             readyQ, aeoiQ, sfnQ, rotateQ;
  logic [BASE_W-1:0] baseQ;
  logic [LINES-1:0] requestQ, serviceQ, maskQ;
  logic             winnerValid;
  logic [IDX_W-1:0] winnerPin;

  irqc_ctrl #(.IS_MASTER(IS_MASTER)) i_ctrl (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .requestQ(requestQ), .serviceQ(serviceQ), .maskQ(maskQ),
    .winnerValid(winnerValid), .winnerPin(winnerPin),
    .stb(stb), .readyQ(readyQ), .aeoiQ(aeoiQ), .sfnQ(sfnQ),
    .rotateQ(rotateQ), .baseQ(baseQ)
  );

  irqc_datapath #(.CASC_LINE(CASC_LINE)) i_datapath (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .ackValid(ackValid), .ackPin(ackPin),
    .stb(stb), .readyQ(readyQ), .aeoiQ(aeoiQ), .sfnQ(sfnQ), .rotateQ(rotateQ),
    .requestQ(requestQ), .serviceQ(serviceQ), .maskQ(maskQ),
    .winnerValid(winnerValid), .winnerPin(winnerPin), .intOut(intOut)
  );

  assign vectorOut = {baseQ, winnerValid ? winnerPin : {IDX_W{1'b1}}};
endmodule

// File: tb/test_prio_irq_controller.sv
module test_prio_irq_controller;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       cpuWr = 1'b0, cpuRd = 1'b0, cpuAddr = 1'b0;
  logic [7:0] cpuWrData = '0;
  logic [7:0] cpuRdData;
  logic       ackValid = 1'b0;
  logic [2:0] ackPin = '0;
  logic       intOut;
  logic [7:0] vectorOut;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  string       tagQ[$];
  logic [7:0]  expQ[$];
  logic [7:0]  actQ[$];
  event        obsEv;

  always #10 clk = ~clk;

  prio_irq_controller i_prio_irq_controller (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .ackValid(ackValid), .ackPin(ackPin), .intOut(intOut), .vectorOut(vectorOut)
  );

  task automatic drain();
    while (actQ.size() > 0) begin
      string t;
      logic [7:0] e, a;
      t = tagQ.pop_front();
      e = expQ.pop_front();
      a = actQ.pop_front();
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", t, a, e);
      end
    end
  endtask

  initial forever begin
    @(obsEv);
    drain();
  end

  task automatic expectVal(input string tag, input logic [7:0] exp, input logic [7:0] act);
    tagQ.push_back(tag);
    expQ.push_back(exp);
    actQ.push_back(act);
    ->obsEv;
    #0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    cpuWr = 1'b1; cpuAddr = a; cpuWrData = d;
    tick(1);
    cpuWr = 1'b0;
  endtask

  task automatic rdCheck(input logic a, input string tag, input logic [7:0] exp);
    cpuRd = 1'b1; cpuAddr = a;
    #1;
    expectVal(tag, exp, cpuRdData);
    tick(1);
    cpuRd = 1'b0;
  endtask

  task automatic ack(input logic [2:0] p);
    ackValid = 1'b1; ackPin = p;
    tick(1);
    ackValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      drain();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    tick(2);
    rstN = 1'b1;
    tick(1);
    // Reset state
    expectVal("R3 reset intOut", 8'h00, {7'd0, intOut});
    rdCheck(1'b1, "R1 reset mask", 8'h00);
    // Not ready: edges ignored
    irqIn[3] = 1'b1;
    tick(2);
    expectVal("R3 unready intOut", 8'h00, {7'd0, intOut});
    rdCheck(1'b0, "R3 unready request", 8'h00);
    irqIn[3] = 1'b0;
    // Initialization with a rejected mode word
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h00);
    irqIn[6] = 1'b1;
    tick(2);
    expectVal("R2 rejected mode keeps intOut low", 8'h00, {7'd0, intOut});
    irqIn[6] = 1'b0;
    wr(1'b1, 8'h01);
    expectVal("R2 ready vector idle", 8'h27, vectorOut);
    wr(1'b1, 8'hF0);
    rdCheck(1'b1, "R2 mask load", 8'hF0);
    wr(1'b1, 8'h00);
    // Request capture and interrupt raise
    irqIn[5] = 1'b1;
    tick(2);
    expectVal("R6 intOut raised", 8'h01, {7'd0, intOut});
    expectVal("R5 vector pin5", 8'h25, vectorOut);
    rdCheck(1'b0, "R4 request readback", 8'h20);
    irqIn[2] = 1'b1;
    tick(1);
    expectVal("R5 higher pin wins", 8'h22, vectorOut);
    expectVal("R6 intOut held", 8'h01, {7'd0, intOut});
    ack(3'd2);
    tick(1);
    expectVal("R5 scan stops at in-service", 8'h27, vectorOut);
    expectVal("R6 intOut drops after accept", 8'h00, {7'd0, intOut});
    rdCheck(1'b0, "R7 request kept while line high", 8'h24);
    wr(1'b0, 8'h0B);
    rdCheck(1'b0, "R12 service readback", 8'h04);
    // Nesting
    irqIn[1] = 1'b1;
    tick(2);
    expectVal("R5 nested vector", 8'h21, vectorOut);
    expectVal("R6 nested raise", 8'h01, {7'd0, intOut});
    irqIn[1] = 1'b0;
    ack(3'd1);
    rdCheck(1'b0, "R7 service after nesting", 8'h06);
    wr(1'b0, 8'h20);
    rdCheck(1'b0, "R8 non-specific eoi", 8'h04);
    wr(1'b0, 8'h62);
    rdCheck(1'b0, "R9 specific eoi", 8'h00);
    expectVal("R7 request cleared line low", 8'h22, vectorOut);
    irqIn[2] = 1'b0;
    ack(3'd2);
    wr(1'b0, 8'hE2);
    rdCheck(1'b0, "R10 rotating eoi clears", 8'h00);
    irqIn[1] = 1'b1;
    tick(1);
    expectVal("R10 rotated order", 8'h25, vectorOut);
    wr(1'b0, 8'hC5);
    expectVal("R10 set priority", 8'h21, vectorOut);
    wr(1'b1, 8'h02);
    expectVal("R5 masked pin skipped", 8'h25, vectorOut);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h4A);
    rdCheck(1'b0, "R12 special mask command ignored", 8'h00);
    // Poll
    wr(1'b0, 8'h0E);
    rdCheck(1'b0, "R13 poll result", 8'h81);
    rdCheck(1'b0, "R13 poll off after read", 8'h22);
    tick(1);
    expectVal("R13 poll accepted drops intOut", 8'h00, {7'd0, intOut});
    wr(1'b0, 8'h0E);
    rdCheck(1'b0, "R13 poll empty", 8'h00);
    wr(1'b0, 8'h20);
    // Re-init with automatic eoi
    wr(1'b1, 8'h55);
    wr(1'b0, 8'h11);
    rdCheck(1'b1, "R1 start clears mask", 8'h00);
    expectVal("R3 intOut low during init", 8'h00, {7'd0, intOut});
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h03);
    tick(1);
    expectVal("R1 pointer reset vector", 8'h41, vectorOut);
    expectVal("R6 raise after init", 8'h01, {7'd0, intOut});
    wr(1'b0, 8'h80);
    irqIn[1] = 1'b0;
    ack(3'd1);
    wr(1'b0, 8'h0B);
    rdCheck(1'b0, "R11 no in-service bit", 8'h00);
    irqIn[0] = 1'b1;
    tick(1);
    expectVal("R11 auto rotation", 8'h45, vectorOut);
    // Re-init with nested-cascade mode
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h11);
    irqIn[0] = 1'b0;
    ack(3'd0);
    wr(1'b0, 8'h20);
    irqIn[2] = 1'b1;
    tick(1);
    expectVal("R14 pin2 winner", 8'h42, vectorOut);
    ack(3'd2);
    wr(1'b0, 8'h0B);
    rdCheck(1'b0, "R14 in-service pin2", 8'h04);
    expectVal("R14 pin2 not blocking", 8'h42, vectorOut);
    expectVal("R14 intOut re-raised", 8'h01, {7'd0, intOut});
    tick(2);
    finishRun();
  end
endmodule